// File: doc/BRIEF.md
# Dual-Mode Jump Register

This block is an 18-cell linear finite state machine. Each cell behaves either as a plain delay stage or as a self-feedback stage, which XORs its own present value into the bit it receives. A single jump-control input decides which role each cell takes. With jump control low the register makes one step of its base sequence. With jump control high every cell takes the opposite role. That adds the identity to the transition matrix, so one clock covers a fixed large number of base steps, and the XOR count is the same in both modes.

A parameter selects one of two cell configurations, one for odd-numbered sections and one for even-numbered sections of a larger generator. The register gives out three things: a key-stream tap, a 9-bit vector for an external key-dependent filter, and its full state for readback. An external injection bit can be XORed into the feedback path, as an initialization phase needs. A synchronous parallel load presets the state.

Top module: `jump_reg_core`

## Requirements
- R1: A synchronous active-high `rst` sets `state_q` to parameter `SEED` (default 18'h00001) on the next rising edge. Reset takes priority over every other input.
- R2: When `load_en` is high and `rst` is low, the next state is `load_val`, with bit 0 going to cell 1. Load takes priority over `step_en` in the same cycle.
- R3: With `rst`, `load_en` and `step_en` all low, the state is held whatever `jump_en` and `inj_bit` are.
- R4: On a base step (`step_en`=1, `jump_en`=0), cell 1 receives `fb ^ inj_bit` and cell i>1 receives the old cell i-1, where fb is the old cell 18. fb is also XORed into cells 4, 9 and 17 (odd type) or cells 7, 9 and 15 (even type). Every cell whose role is feedback also XORs in its own old value. Listed from cell 18 down to cell 1, the roles are FSFFFSFFFFSSSSSFSS (odd) and SSFSFFFFFFSFSSSFSS (even), where F means feedback and S means delay.
- R5: On a jump step (`step_en`=1, `jump_en`=1), every cell takes the role opposite to R4. The next state therefore equals the base-step result XOR the old state.
- R6: `inj_bit` is XORed into the value entering cell 1 on every step, base or jump, and has no effect otherwise.
- R7: `ks_tap` equals the current value of cell 17 (`state_q[16]`).
- R8: `filt_vec` bits 0..8 carry cells 1,2,4,5,6,7,9,10,11 (odd type) or cells 1,2,3,4,5,7,9,10,11 (even type), with cell 1 in bit 0.
- R9: On a base step, the new cell 2 equals the old cell 1.
- R10: An all-zero state stays all-zero under any step while `inj_bit` is 0.
- R11: Parameter `SECTION_ODD`=1 selects the odd configuration and 0 selects the even configuration (roles, insertion cells and filter cells).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the register this cycle |
| jump_en | input | 1 | Jump control: invert all cell roles |
| inj_bit | input | 1 | External bit XORed into cell 1 input on a step |
| load_en | input | 1 | Parallel load strobe |
| load_val | input | 18 | Parallel load value, bit 0 to cell 1 |
| state_q | output | 18 | Register state readback, bit 0 is cell 1 |
| ks_tap | output | 1 | Key-stream contribution (cell 17) |
| filt_vec | output | 9 | Filter input vector |

## Verification
A load and a step, base or jump, can be requested in the same cycle. Long random runs assert both strobes together many times, and directed cycles do so right after a jump sequence. The reference model applies load priority, and the bench compares the full state on the following cycle, so a design that advances the loaded value, or advances the old state and drops the load, shows up at once. Reset raised during a step is judged the same way against the seed.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int JR_CELLS = 18;
  localparam int JR_FILT  = 9;

  // Feedback-role mask for jump control low; bit c-1 is cell c, 1 = feedback.
  function automatic logic [JR_CELLS-1:0] base_roles(input bit odd);
    return odd ? 18'b101110111100000100 : 18'b001011111101000100;
  endfunction

  // Cells that receive the feedback bit (the cell after each tap, plus cell 1).
  function automatic logic [JR_CELLS-1:0] fb_points(input bit odd);
    return odd ? 18'b010000000100001001 : 18'b000100000101000001;
  endfunction

  // Cell number (1-based) that drives filter bit k.
  function automatic int filt_cell(input bit odd, input int k);
    int c;
    case (k)
      0: c = 1;
      1: c = 2;
      2: c = odd ? 4 : 3;
      3: c = odd ? 5 : 4;
      4: c = odd ? 6 : 5;
      5: c = 7;
      6: c = 9;
      7: c = 10;
      default: c = 11;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/jr_role_sel.sv
module jr_role_sel #(
  parameter bit SECTION_ODD = 1'b1,
  parameter int N = jr_pkg::JR_CELLS
) (
  input  logic         jump_en,
  output logic [N-1:0] fb_role,
  output logic [N-1:0] fb_ins
);
  localparam logic [N-1:0] ROLES = jr_pkg::base_roles(SECTION_ODD);
  localparam logic [N-1:0] INS   = jr_pkg::fb_points(SECTION_ODD);

  always_comb begin
    fb_role = jump_en ? ~ROLES : ROLES;
    fb_ins  = INS;
  end
endmodule

// File: rtl/jr_next.sv
module jr_next #(
  parameter int N = jr_pkg::JR_CELLS
) (
  input  logic [N-1:0] cur,
  input  logic [N-1:0] fb_role,
  input  logic [N-1:0] fb_ins,
  input  logic         inj_bit,
  output logic [N-1:0] nxt
);
  logic fb;
  assign fb = cur[N-1];

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i == 0) begin : g_first
      assign nxt[i] = inj_bit ^ (fb_ins[i] & fb) ^ (fb_role[i] & cur[i]);
    end else begin : g_rest
      assign nxt[i] = cur[i-1] ^ (fb_ins[i] & fb) ^ (fb_role[i] & cur[i]);
    end
  end
endmodule

// File: rtl/jr_filter_pick.sv
module jr_filter_pick #(
  parameter bit SECTION_ODD = 1'b1,
  parameter int N = jr_pkg::JR_CELLS,
  parameter int W = jr_pkg::JR_FILT
) (
  input  logic [N-1:0] cur,
  output logic [W-1:0] filt
);
  for (genvar k = 0; k < W; k++) begin : g_pick
    localparam int IDX = jr_pkg::filt_cell(SECTION_ODD, k) - 1;
    assign filt[k] = cur[IDX];
  end
endmodule

// File: rtl/jump_reg_core.sv
module jump_reg_core #(
  parameter bit SECTION_ODD = 1'b1,
  parameter int N = jr_pkg::JR_CELLS,
  parameter int W = jr_pkg::JR_FILT,
  parameter logic [N-1:0] SEED = {{(N-1){1'b0}}, 1'b1}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step_en,
  input  logic         jump_en,
  input  logic         inj_bit,
  input  logic         load_en,
  input  logic [N-1:0] load_val,
  output logic [N-1:0] state_q,
  output logic         ks_tap,
  output logic [W-1:0] filt_vec
);
  localparam int TAP_IDX = 16;

  logic [N-1:0] fb_role, fb_ins, nxt;

  jr_role_sel #(.SECTION_ODD(SECTION_ODD), .N(N)) u_roles (
    .jump_en (jump_en),
    .fb_role (fb_role),
    .fb_ins  (fb_ins)
  );

  jr_next #(.N(N)) u_next (
    .cur     (state_q),
    .fb_role (fb_role),
    .fb_ins  (fb_ins),
    .inj_bit (inj_bit),
    .nxt     (nxt)
  );

  jr_filter_pick #(.SECTION_ODD(SECTION_ODD), .N(N), .W(W)) u_filt (
    .cur  (state_q),
    .filt (filt_vec)
  );

  always_ff @(posedge clk) begin
    if (rst)          state_q <= SEED;
    else if (load_en) state_q <= load_val;
    else if (step_en) state_q <= nxt;
  end

  assign ks_tap = state_q[TAP_IDX];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!load_en && !step_en) |=> $stable(state_q)); // R3
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load_en |=> state_q == $past(load_val)); // R2
  AST_BASE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (step_en && !jump_en && !load_en) |=> state_q[1] == $past(state_q[0])); // R9
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && !inj_bit && state_q == '0) |=> state_q == '0); // R10
endmodule

// File: tb/jump_reg_core_tb.sv
module jump_reg_core_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1, step_en = 1'b0, jump_en = 1'b0, inj_bit = 1'b0, load_en = 1'b0;
  logic [17:0] load_val = '0;
  logic [17:0] st_o, st_e;
  logic tap_o, tap_e;
  logic [8:0] fv_o, fv_e;

  jump_reg_core #(.SECTION_ODD(1'b1)) u_dut (
    .clk(clk), .rst(rst), .step_en(step_en), .jump_en(jump_en), .inj_bit(inj_bit),
    .load_en(load_en), .load_val(load_val), .state_q(st_o), .ks_tap(tap_o), .filt_vec(fv_o));
  jump_reg_core #(.SECTION_ODD(1'b0)) u_dut_even (
    .clk(clk), .rst(rst), .step_en(step_en), .jump_en(jump_en), .inj_bit(inj_bit),
    .load_en(load_en), .load_val(load_val), .state_q(st_e), .ks_tap(tap_e), .filt_vec(fv_e));

  int vectors = 0, miscompares = 0;
  logic [17:0] m_o = 18'h00001, m_e = 18'h00001;
  string tag = "R1";
  bit finished = 1'b0;

  function automatic bit is_ins(bit odd, int c);
    if (c == 1) return 1'b1;
    if (odd) return (c - 1 == 3) || (c - 1 == 8) || (c - 1 == 16);
    return (c - 1 == 6) || (c - 1 == 8) || (c - 1 == 14);
  endfunction

  function automatic logic [17:0] mstep(logic [17:0] s, bit odd, bit jmp, bit inj);
    string r;
    logic [17:0] n;
    r = odd ? "FSFFFSFFFFSSSSSFSS" : "SSFSFFFFFFSFSSSFSS";
    for (int c = 1; c <= 18; c++) begin
      logic b;
      b = (c == 1) ? inj : s[(c >= 2) ? c - 2 : 0];
      if (is_ins(odd, c)) b ^= s[17];
      if ((r[18 - c] == "F") ^ jmp) b ^= s[c - 1];
      n[c - 1] = b;
    end
    return n;
  endfunction

  function automatic logic [8:0] mfilt(logic [17:0] s, bit odd);
    int lo[9] = '{1, 2, 4, 5, 6, 7, 9, 10, 11};
    int le[9] = '{1, 2, 3, 4, 5, 7, 9, 10, 11};
    logic [8:0] f;
    for (int k = 0; k < 9; k++) f[k] = s[(odd ? lo[k] : le[k]) - 1];
    return f;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(tag, {14'd0, st_o}, {14'd0, m_o});
    chk({tag, "/R11"}, {14'd0, st_e}, {14'd0, m_e});
    chk("R7", {31'd0, tap_o}, {31'd0, m_o[16]});
    chk("R7", {31'd0, tap_e}, {31'd0, m_e[16]});
    chk("R8", {23'd0, fv_o}, {23'd0, mfilt(m_o, 1'b1)});
    chk("R8/R11", {23'd0, fv_e}, {23'd0, mfilt(m_e, 1'b0)});
  endtask

  task automatic cyc(bit r, bit st, bit j, bit inj, bit ld, logic [17:0] lv);
    @(negedge clk);
    compare();
    rst = r; step_en = st; jump_en = j; inj_bit = inj; load_en = ld; load_val = lv;
    if (r) begin m_o = 18'h00001; m_e = 18'h00001; end
    else if (ld) begin m_o = lv; m_e = lv; end
    else if (st) begin
      m_o = mstep(m_o, 1'b1, j, inj);
      m_e = mstep(m_e, 1'b0, j, inj);
    end
  endtask

  initial begin
    tag = "R1";
    repeat (3) cyc(1, 1, 1, 1, 1, 18'h3FFFF);
    tag = "R4";
    repeat (60) cyc(0, 1, 0, 0, 0, '0);
    tag = "R9";
    cyc(0, 0, 0, 0, 1, 18'h2AAAB);
    repeat (20) cyc(0, 1, 0, 0, 0, '0);
    tag = "R3";
    for (int i = 0; i < 12; i++) cyc(0, 0, i[0], i[1], 0, 18'h15555);
    tag = "R5";
    cyc(0, 0, 0, 0, 1, 18'h20001);
    repeat (50) cyc(0, 1, 1, 0, 0, '0);
    tag = "R2";
    cyc(0, 1, 1, 1, 1, 18'h1234F);
    cyc(0, 1, 0, 0, 1, 18'h3C0F0);
    cyc(0, 0, 0, 0, 0, '0);
    tag = "R6";
    for (int i = 0; i < 40; i++) cyc(0, 1, i[2], i[0] ^ i[3], 0, '0);
    tag = "R10";
    cyc(0, 0, 0, 0, 1, 18'h00000);
    repeat (10) cyc(0, 1, 0, 0, 0, '0);
    repeat (10) cyc(0, 1, 1, 0, 0, '0);
    cyc(0, 1, 0, 1, 0, '0);
    repeat (5) cyc(0, 1, 1, 0, 0, '0);
    tag = "R1";
    cyc(0, 1, 1, 0, 1, 18'h3FFFF);
    cyc(1, 1, 1, 1, 0, '0);
    cyc(0, 0, 0, 0, 0, '0);
    tag = "R4";
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc(rv[31:29] == 3'd0, rv[0] | rv[1], rv[2], rv[3], rv[7:4] == 4'd0, rv[25:8]);
    end
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule